// File: doc/BRIEF.md
# Receive Message Queue with Fill-Threshold Interrupt

This block holds received messages in a circular queue and tells software when to come and read them. A receiver pushes each completed message through a valid/ready write stream. Software pulls messages from a valid/ready read stream; asserting the read ready is the pop strobe. The usable depth is picked at run time from a 3-bit code, up to 32 entries.

A sticky receive request flag is set in one of two ways. In level mode it is set when a push brings the fill count up to a threshold, given in eighths of the depth. In per-message mode every stored message sets it. The flag reaches the interrupt pin only while the queue's own enable is set, and only software clears it. A message that arrives while the queue is full is dropped. The drop sets a sticky lost flag, which drives a global error interrupt when the module-wide lost-interrupt enable is set.

Back-pressure rules: `wr_ready` is high whenever the queue is enabled with a non-zero depth. It does not fall when the queue is full, because a full queue drops the message instead of stalling the receiver. A write transfer is `wr_valid && wr_ready`. A read transfer is `rd_valid && rd_ready`. `rd_data` shows the oldest entry whenever `rd_valid` is high. Configuration is changed only while `cfg_en` is low, except the threshold, the mode and the interrupt enables.

Top module: `msgq_irq_top`

## Requirements
- R1: Messages leave in the order they were accepted. `rd_valid` is high exactly when the queue is enabled and not empty. `wr_ready` is low while `cfg_en` is 0.
- R2: `cfg_depth` maps 0→0 (the queue is unusable and `wr_ready` is 0), 1→4, 2→8, 3→16, and 4 to 7→32 entries. `full` rises when the count equals the mapped depth.
- R3: With `cfg_mode`=0, a push that raises the count from below the threshold up to the threshold sets `rx_flag`. The threshold is ceil(depth·(`cfg_thr`+1)/8); `cfg_thr`=7 means full. Further pushes at or above the threshold do not set the flag again.
- R4: With `cfg_mode`=1, every accepted push sets `rx_flag`.
- R5: `rx_irq` equals `rx_flag` AND `cfg_rxie`. The flag is still recorded while `cfg_rxie` is 0.
- R6: `rx_flag` holds until a cycle with `irq_clr`=1 and no new set event. Dropping `cfg_en` does not clear it.
- R7: A push while full is discarded and leaves the count and the stored messages unchanged. It sets the sticky `lost_flag`, which is cleared by `lost_clr`. `err_irq` equals `lost_flag` AND `lost_ie`.
- R8: Driving `cfg_en` low empties the queue (count 0, pointers at entry 0) on the next clock edge.
- R9: A pop while the queue is empty is ignored: the count stays 0.
- R10: With depth 4, the odd-eighth threshold codes round up to whole messages: codes 0, 2, 4 and 6 give thresholds of 1, 2, 3 and 4.
- R11: After reset the queue is empty (`empty`=1, `full`=0, `count`=0) and both flags are 0. `count` never exceeds the mapped depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Queue enable; low empties the queue |
| cfg_depth | input | 3 | Depth code |
| cfg_thr | input | 3 | Threshold in eighths minus one |
| cfg_mode | input | 1 | 0 = level threshold, 1 = every message |
| cfg_rxie | input | 1 | Receive interrupt enable |
| lost_ie | input | 1 | Module-wide lost-message interrupt enable |
| irq_clr | input | 1 | Clears rx_flag |
| lost_clr | input | 1 | Clears lost_flag |
| wr_valid | input | 1 | Receiver offers a message |
| wr_ready | output | 1 | Queue accepts transfers |
| wr_data | input | DATA_W | Incoming message |
| rd_valid | output | 1 | Oldest message available |
| rd_ready | input | 1 | Pop strobe |
| rd_data | output | DATA_W | Oldest message |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| count | output | 6 | Fill count |
| rx_flag | output | 1 | Sticky receive request |
| rx_irq | output | 1 | Receive interrupt |
| lost_flag | output | 1 | Sticky lost-message status |
| err_irq | output | 1 | Global error interrupt |

## Verification
Pointer, count and flag updates are all registered on the edge that takes the transfer. Their results are due one cycle after the stimulus is presented. `rx_irq`, `err_irq`, `wr_ready`, `rd_valid` and `rd_data` are combinational from that state and the enables. The bench drives on the falling edge, lets one rising edge pass, and samples on the next falling edge. It reads `rd_data` before asserting the pop, since the head entry is already visible. Each scoreboard comparison of a popped message therefore lines up with the rising edge that removes it.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  parameter int unsigned ADDR_W = 5;
  parameter int unsigned CNT_W  = ADDR_W + 1;

  function automatic logic [CNT_W-1:0] depth_of(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(0);
      3'd1:    return CNT_W'(4);
      3'd2:    return CNT_W'(8);
      3'd3:    return CNT_W'(16);
      default: return CNT_W'(32);
    endcase
  endfunction

  // ceil(depth * (code+1) / 8)
  function automatic logic [CNT_W-1:0] thr_of(input logic [CNT_W-1:0] depth,
                                              input logic [2:0] code);
    int unsigned prod;
    prod = int'(depth) * (int'(code) + 1);
    return CNT_W'((prod + 7) >> 3);
  endfunction
endpackage

// File: rtl/msgq_store.sv
module msgq_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned ENTRIES = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
  import msgq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  depth,
  input  logic              push_req,
  input  logic              pop_req,
  output logic              usable,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              lost,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  logic [CNT_W-1:0] last_idx;

  assign usable   = en && (depth != '0);
  assign last_idx = depth - CNT_W'(1);
  assign empty    = (count == '0);
  assign full     = usable && (count == depth);
  assign push_ok  = usable && push_req && !full;
  assign lost     = usable && push_req && full;
  assign pop_ok   = usable && pop_req && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (!en) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok)
        wptr <= ({1'b0, wptr} == last_idx) ? '0 : wptr + ADDR_W'(1);
      if (pop_ok)
        rptr <= ({1'b0, rptr} == last_idx) ? '0 : rptr + ADDR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/msgq_irq.sv
module msgq_irq
  import msgq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic [CNT_W-1:0] thr,
  input  logic [CNT_W-1:0] count,
  input  logic             push_ok,
  input  logic             pop_ok,
  input  logic             lost,
  input  logic             irq_clr,
  input  logic             lost_clr,
  output logic             rx_flag,
  output logic             lost_flag
);
  logic thr_hit, msg_hit, rx_set;

  // level mode: only the push that lands exactly on the threshold
  assign thr_hit = !mode && push_ok && !pop_ok && ((count + CNT_W'(1)) == thr);
  assign msg_hit = mode && push_ok;
  assign rx_set  = thr_hit || msg_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flag   <= 1'b0;
      lost_flag <= 1'b0;
    end else begin
      if (rx_set)       rx_flag <= 1'b1;
      else if (irq_clr) rx_flag <= 1'b0;
      if (lost)          lost_flag <= 1'b1;
      else if (lost_clr) lost_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/msgq_irq_top.sv
module msgq_irq_top
  import msgq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [2:0]        cfg_depth,
  input  logic [2:0]        cfg_thr,
  input  logic              cfg_mode,
  input  logic              cfg_rxie,
  input  logic              lost_ie,
  input  logic              irq_clr,
  input  logic              lost_clr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count,
  output logic              rx_flag,
  output logic              rx_irq,
  output logic              lost_flag,
  output logic              err_irq
);
  logic [CNT_W-1:0]  depth, thr;
  logic [ADDR_W-1:0] wptr, rptr;
  logic usable, push_ok, pop_ok, lost;

  assign depth = depth_of(cfg_depth);
  assign thr   = thr_of(depth, cfg_thr);

  msgq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .depth(depth),
    .push_req(wr_valid), .pop_req(rd_ready),
    .usable(usable), .push_ok(push_ok), .pop_ok(pop_ok), .lost(lost),
    .wptr(wptr), .rptr(rptr), .count(count), .empty(empty), .full(full)
  );

  msgq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(rd_data)
  );

  msgq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .thr(thr), .count(count),
    .push_ok(push_ok), .pop_ok(pop_ok), .lost(lost),
    .irq_clr(irq_clr), .lost_clr(lost_clr),
    .rx_flag(rx_flag), .lost_flag(lost_flag)
  );

  assign wr_ready = usable;
  assign rd_valid = usable && !empty;
  assign rx_irq   = rx_flag && cfg_rxie;
  assign err_irq  = lost_flag && lost_ie;
endmodule

// File: rtl/msgq_irq_chk.sv
module msgq_irq_chk
  import msgq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic [2:0]       cfg_depth,
  input logic             irq_clr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_ready,
  input logic             empty,
  input logic             full,
  input logic [CNT_W-1:0] count,
  input logic             rx_flag,
  input logic             lost_flag
);
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth_of(cfg_depth));

  assert_lost_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && full) |=> lost_flag);

  assert_lost_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && full && !rd_ready) |=> (count == $past(count)));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !irq_clr) |=> rx_flag);

  assert_disable_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (empty && count == '0));

  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_valid) |=> empty);
endmodule

bind msgq_irq_top msgq_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_depth(cfg_depth),
  .irq_clr(irq_clr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_ready(rd_ready), .empty(empty), .full(full), .count(count),
  .rx_flag(rx_flag), .lost_flag(lost_flag)
);

// File: tb/msgq_irq_top_bench.sv
module msgq_irq_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 0, cfg_mode = 0, cfg_rxie = 0, lost_ie = 0;
  logic [2:0] cfg_depth = 3'd2, cfg_thr = 3'd3;
  logic irq_clr = 0, lost_clr = 0, wr_valid = 0, rd_ready = 0;
  logic [15:0] wr_data = '0;
  logic wr_ready, rd_valid, empty, full, rx_flag, rx_irq, lost_flag, err_irq;
  logic [15:0] rd_data;
  logic [5:0] count;

  int n_run = 0, n_fail = 0, mdepth = 8;
  bit done = 0;
  logic [15:0] q[$];

  always #2.5 clk = ~clk;

  msgq_irq_top u_msgq_irq_top (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_depth(cfg_depth),
    .cfg_thr(cfg_thr), .cfg_mode(cfg_mode), .cfg_rxie(cfg_rxie),
    .lost_ie(lost_ie), .irq_clr(irq_clr), .lost_clr(lost_clr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .empty(empty), .full(full), .count(count), .rx_flag(rx_flag),
    .rx_irq(rx_irq), .lost_flag(lost_flag), .err_irq(err_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: presents one message and records it if the model has room
  task automatic push(input logic [15:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
    if (q.size() < mdepth) q.push_back(d);
  endtask

  // monitor: compares the head against the scoreboard, then pops it
  task automatic monitor_pop();
    @(negedge clk);
    check("R1 rd_valid", int'(rd_valid), 1);
    check("R1 order", int'(rd_data), int'(q[0]));
    rd_ready = 1;
    @(negedge clk); rd_ready = 0;
    void'(q.pop_front());
  endtask

  task automatic drain();
    while (q.size() > 0) monitor_pop();
  endtask

  task automatic clear_rx();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic setup(input logic [2:0] dc, input logic [2:0] tc, input int md);
    @(negedge clk); cfg_en = 0;
    @(negedge clk); cfg_depth = dc; cfg_thr = tc; mdepth = md; q.delete(); cfg_en = 1;
    @(negedge clk);
  endtask

  initial begin
    int exp_thr[4] = '{1, 2, 3, 4};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset empty", int'(empty), 1);
    check("R11 reset full", int'(full), 0);
    check("R11 reset count", int'(count), 0);
    check("R11 reset rx_flag", int'(rx_flag), 0);
    check("R11 reset lost_flag", int'(lost_flag), 0);
    check("R1 ready low when disabled", int'(wr_ready), 0);

    // level threshold, depth 8, code 3 -> 4 messages
    cfg_rxie = 1;
    setup(3'd2, 3'd3, 8);
    for (int i = 0; i < 3; i++) push(16'(100 + i));
    check("R3 below threshold", int'(rx_flag), 0);
    push(16'd103);
    check("R3 flag at threshold", int'(rx_flag), 1);
    check("R5 irq enabled", int'(rx_irq), 1);
    clear_rx();
    check("R6 clear", int'(rx_flag), 0);
    push(16'd104);
    check("R3 no refire above threshold", int'(rx_flag), 0);
    check("R11 count", int'(count), 5);
    drain();
    check("R1 empty after drain", int'(empty), 1);
    check("R1 rd_valid low when empty", int'(rd_valid), 0);
    @(negedge clk); rd_ready = 1;
    @(negedge clk); rd_ready = 0;
    check("R9 pop on empty count", int'(count), 0);
    check("R9 pop on empty flag", int'(empty), 1);

    // enable masks irq, flag still set; disable keeps flag
    cfg_rxie = 0;
    for (int i = 0; i < 4; i++) push(16'(200 + i));
    check("R5 flag recorded", int'(rx_flag), 1);
    check("R5 irq masked", int'(rx_irq), 0);
    @(negedge clk); cfg_en = 0;
    @(negedge clk);
    q.delete();
    check("R8 disable empties", int'(count), 0);
    check("R8 empty", int'(empty), 1);
    check("R6 flag survives disable", int'(rx_flag), 1);
    clear_rx();
    cfg_rxie = 1;

    // depth 4, threshold full, lost message
    lost_ie = 1;
    setup(3'd1, 3'd7, 4);
    for (int i = 0; i < 4; i++) push(16'(300 + i));
    check("R2 depth4 full", int'(full), 1);
    check("R2 depth4 count", int'(count), 4);
    check("R3 full threshold", int'(rx_flag), 1);
    push(16'd999);
    check("R7 lost flag", int'(lost_flag), 1);
    check("R7 err_irq", int'(err_irq), 1);
    check("R7 count unchanged", int'(count), 4);
    check("R1 ready while full", int'(wr_ready), 1);
    drain();
    @(negedge clk); lost_clr = 1;
    @(negedge clk); lost_clr = 0;
    check("R7 lost clear", int'(lost_flag), 0);
    check("R7 err_irq clear", int'(err_irq), 0);

    // depth 4 odd-eighth codes round up
    for (int k = 0; k < 4; k++) begin
      clear_rx();
      @(negedge clk); cfg_thr = 3'(2 * k);
      for (int i = 0; i < exp_thr[k] - 1; i++) push(16'(400 + 10 * k + i));
      check("R10 before rounded threshold", int'(rx_flag), 0);
      push(16'(409 + 10 * k));
      check("R10 at rounded threshold", int'(rx_flag), 1);
      drain();
    end

    // per-message mode
    cfg_mode = 1;
    setup(3'd2, 3'd7, 8);
    for (int k = 0; k < 3; k++) begin
      clear_rx();
      check("R4 cleared", int'(rx_flag), 0);
      push(16'(500 + k));
      check("R4 flag per message", int'(rx_flag), 1);
    end
    drain();
    cfg_mode = 0;

    // depth 16
    setup(3'd3, 3'd7, 16);
    for (int i = 0; i < 15; i++) push(16'(600 + i));
    check("R2 depth16 not full at 15", int'(full), 0);
    push(16'd615);
    check("R2 depth16 full", int'(full), 1);
    drain();

    // depth code 0 unusable
    setup(3'd0, 3'd7, 0);
    check("R2 depth0 not ready", int'(wr_ready), 0);

    // reserved code -> 32
    setup(3'd6, 3'd7, 32);
    for (int i = 0; i < 32; i++) push(16'(700 + i));
    check("R2 reserved code full", int'(full), 1);
    check("R2 reserved code count", int'(count), 32);
    drain();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule